// File: doc/BRIEF.md
# Configurable UART with FIFOs

This block is a full-duplex asynchronous serial port for a system-on-chip. It has its own baud-rate generator: a prescaler feeds a 16-bit reload counter, and that counter produces an oversampling tick. Each bit on the line lasts eight of these ticks. The character format is chosen at run time. Software sets the number of data bits, whether a parity bit is sent and which parity rule it follows, and whether hardware flow control is used.

The host side is a simple register-style interface:

- A push strobe writes a character into a four-entry transmit queue.
- A pop strobe removes the head of a four-entry receive queue.
- The head of the receive queue is always visible on `rx_data`.
- Full and empty flags are provided for both queues.

Four sticky error flags record:

- a parity mismatch,
- a missing stop bit,
- a character lost because the receive queue was full,
- a receive line held low for longer than any legal character.

A single clear strobe resets all four flags.

Top module: `uart_fifo_port`

## Requirements
- R1: The bit time on `txd` is exactly 8 x (`cfg_reload` + 1) x 2^`cfg_pre` clock cycles.
- R2: The transmit line idles high. A character is sent as one low start bit, then the data bits with the least significant bit first, then the parity bit when it is enabled, then one high stop bit.
- R3: `cfg_len` codes 0, 1, 2, 3 and 4 select 5, 6, 7, 8 and 9 data bits. Transmit ignores the data bits above the selected length. Received characters are stored zero-extended to 9 bits.
- R4: When `cfg_par_en` is 1, the parity bit follows `cfg_par_mode`:
  - 0: odd (the data bits plus the parity bit hold an odd number of ones),
  - 1: even,
  - 2: parity bit always 1,
  - 3: parity bit always 0.
- R5: A received parity bit that differs from the R4 rule sets the sticky `err_parity` flag. The character is still stored.
- R6: The receiver takes each bit as the majority of three samples around the bit centre. A low pulse on `rxd` shorter than half a bit does not start a character, and a two-cycle glitch at a bit centre does not change the received value.
- R7: A stop bit that samples low sets the sticky `err_frame` flag and discards the character. The receiver then waits for `rxd` to return high.
- R8: Each direction has a 4-entry first-in first-out queue. A push into a full transmit queue is ignored. After reset, both queues are empty and `txd` is high.
- R9: A character that completes while the receive queue is full is dropped and sets the sticky `err_overrun` flag. The stored characters are kept in their original order.
- R10: While `cfg_flow_en` is 1, a new character starts on `txd` only while `cts_n` is low. A held-off queue is sent in order once `cts_n` goes low.
- R11: `rts_n` is 1 exactly when `cfg_flow_en` is 1 and the receive queue is full. Otherwise it is 0.
- R12: `brk_det` is set (sticky) once `rxd` has stayed low for 12 bit times. A legal all-zero character does not set it.
- R13: A `clr_err` pulse clears `err_parity`, `err_frame`, `err_overrun` and `brk_det`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_len | input | 3 | Data length code (0..4 gives 5..9 bits) |
| cfg_par_en | input | 1 | Enables the parity bit |
| cfg_par_mode | input | 2 | Parity rule: 0 odd, 1 even, 2 one, 3 zero |
| cfg_flow_en | input | 1 | Enables CTS/RTS flow control |
| cfg_pre | input | 2 | Prescaler select: divide by 2^cfg_pre |
| cfg_reload | input | 16 | Reload value of the baud counter |
| tx_push | input | 1 | Writes `tx_data` into the transmit queue |
| tx_data | input | 9 | Character to transmit |
| tx_full | output | 1 | Transmit queue holds 4 entries |
| tx_empty | output | 1 | Transmit queue is empty |
| rx_pop | input | 1 | Removes the head of the receive queue |
| rx_data | output | 9 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue is empty |
| rx_full | output | 1 | Receive queue holds 4 entries |
| clr_err | input | 1 | Clears all sticky flags |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky receive overrun |
| brk_det | output | 1 | Sticky line-break detection |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |

## Verification
The bench decodes `txd` with its own mid-bit sampler, for every length code paired with a different parity rule. A wrong mask or a wrong parity polarity shows up as a wrong decoded value. It measures the width of the start bit with a non-unity prescaler, so a divider that is off by one cycle is caught.

On the receive side, the bench drives:

- a short false start and a centre glitch, which would leave a spurious character or corrupt a bit if the majority vote or the start check were missing;
- a bad stop bit, which a careless receiver would store instead of discarding;
- five characters into a four-entry queue, where a wrong full check would overwrite the oldest character or fail to raise RTS;
- a long low line against an all-zero character, so a break threshold set too low fires on legal data.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;
    localparam int OVS      = 8;
    localparam int MAX_DATA = 9;
    localparam int FRAME_W  = MAX_DATA + 2;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_MARK  = 2'd2,
        PAR_SPACE = 2'd3
    } par_mode_e;

    typedef struct packed {
        logic [2:0] len_code;
        logic       par_en;
        par_mode_e  par_mode;
    } char_fmt_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD
    } rx_state_e;

    // Number of data bits for a length code (codes above 4 clamp to 9).
    function automatic logic [3:0] data_bits(input logic [2:0] code);
        return (code > 3'd4) ? 4'd9 : 4'(code) + 4'd5;
    endfunction

    function automatic logic [MAX_DATA-1:0] data_mask(input logic [2:0] code);
        return 9'h1FF >> (4'd9 - data_bits(code));
    endfunction

    function automatic logic par_bit(input logic [MAX_DATA-1:0] d, input char_fmt_t f);
        logic p;
        p = ^(d & data_mask(f.len_code));
        case (f.par_mode)
            PAR_ODD:  return ~p;
            PAR_EVEN: return p;
            PAR_MARK: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int RELOAD_W = 16,
    parameter int SEL_W    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SEL_W-1:0]    pre_sel,
    input  logic [RELOAD_W-1:0] reload,
    output logic                tick
);
    localparam int PCW = (1 << SEL_W) - 1;

    logic [PCW-1:0]      pcnt;
    logic [PCW-1:0]      div_m1;
    logic [RELOAD_W-1:0] rcnt;
    logic                pre_tick;

    assign div_m1   = PCW'((32'd1 << pre_sel) - 32'd1);
    assign pre_tick = (pcnt >= div_m1);
    assign tick     = pre_tick && (rcnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
            rcnt <= '0;
        end else begin
            pcnt <= pre_tick ? '0 : pcnt + 1'b1;
            if (pre_tick) begin
                rcnt <= (rcnt == '0) ? reload : rcnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_sync_fifo.sv
module uart_sync_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  char_fmt_t           fmt,
    input  logic                cts_ok,
    input  logic                have_data,
    input  logic [MAX_DATA-1:0] din,
    output logic                take,
    output logic                txd
);
    localparam int CW = $clog2(OVS);

    logic               busy;
    logic [CW-1:0]      sub;
    logic [3:0]         left;
    logic [FRAME_W-1:0] sh, frame;
    logic [3:0]         nd;

    assign nd   = data_bits(fmt.len_code);
    assign take = tick && !busy && have_data && cts_ok;

    // Bits that follow the start bit: data, optional parity, stop.
    always_comb begin
        frame = '0;
        frame[MAX_DATA-1:0] = din & data_mask(fmt.len_code);
        if (fmt.par_en) frame[nd] = par_bit(din, fmt);
        frame[nd + {3'b0, fmt.par_en}] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sub  <= '0;
            left <= '0;
            sh   <= '0;
            txd  <= 1'b1;
        end else if (tick) begin
            if (!busy) begin
                if (take) begin
                    busy <= 1'b1;
                    txd  <= 1'b0;
                    sub  <= '0;
                    sh   <= frame;
                    left <= nd + {3'b0, fmt.par_en} + 4'd1;
                end
            end else begin
                sub <= sub + 1'b1;
                if (sub == CW'(OVS - 1)) begin
                    if (left == '0) begin
                        busy <= 1'b0;
                    end else begin
                        txd  <= sh[0];
                        sh   <= sh >> 1;
                        left <= left - 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  char_fmt_t           fmt,
    input  logic                rxd_raw,
    output logic                got,
    output logic [MAX_DATA-1:0] got_data,
    output logic                frm_err,
    output logic                par_err,
    output logic                brk_hit
);
    localparam int CW        = $clog2(OVS);
    localparam int BRK_TICKS = 12 * OVS;
    localparam int BCW       = $clog2(BRK_TICKS + 1);
    localparam logic [CW-1:0] S_A   = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] S_B   = CW'(OVS/2);
    localparam logic [CW-1:0] S_C   = CW'(OVS/2 + 1);
    localparam logic [CW-1:0] S_END = CW'(OVS - 1);

    rx_state_e         st;
    logic              s1, rxl;
    logic              s3, s4, maj;
    logic [CW-1:0]     cnt;
    logic [3:0]        idx, nd, nb;
    logic [MAX_DATA:0] fr;
    logic [BCW-1:0]    lowcnt;

    assign nd  = data_bits(fmt.len_code);
    assign nb  = nd + {3'b0, fmt.par_en};
    assign maj = (s3 & s4) | (s3 & rxl) | (s4 & rxl);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= 1'b1;
            rxl <= 1'b1;
        end else begin
            s1  <= rxd_raw;
            rxl <= s1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= RX_IDLE;
            cnt      <= '0;
            idx      <= '0;
            fr       <= '0;
            s3       <= 1'b1;
            s4       <= 1'b1;
            got      <= 1'b0;
            got_data <= '0;
            frm_err  <= 1'b0;
            par_err  <= 1'b0;
        end else begin
            got     <= 1'b0;
            frm_err <= 1'b0;
            par_err <= 1'b0;
            if (st == RX_HOLD) begin
                if (rxl) st <= RX_IDLE;
            end else if (tick) begin
                if (cnt == S_A) s3 <= rxl;
                if (cnt == S_B) s4 <= rxl;
                cnt <= cnt + 1'b1;
                case (st)
                    RX_IDLE: begin
                        if (!rxl) begin
                            st  <= RX_START;
                            cnt <= CW'(1);
                            fr  <= '0;
                        end else begin
                            cnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == S_C && maj) begin
                            st <= RX_IDLE;
                        end else if (cnt == S_END) begin
                            st  <= RX_DATA;
                            idx <= '0;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == S_C) fr[idx] <= maj;
                        if (cnt == S_END) begin
                            if (idx == nb - 4'd1) st <= RX_STOP;
                            else                  idx <= idx + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == S_C) begin
                            if (maj) begin
                                got      <= 1'b1;
                                got_data <= fr[MAX_DATA-1:0] & data_mask(fmt.len_code);
                                par_err  <= fmt.par_en &&
                                            (fr[nd] != par_bit(fr[MAX_DATA-1:0], fmt));
                                st       <= RX_IDLE;
                            end else begin
                                frm_err <= 1'b1;
                                st      <= RX_HOLD;
                            end
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    // Low-line duration counter for break detection.
    always_ff @(posedge clk) begin
        if (rst) begin
            lowcnt  <= '0;
            brk_hit <= 1'b0;
        end else begin
            brk_hit <= 1'b0;
            if (tick) begin
                if (rxl) begin
                    lowcnt <= '0;
                end else if (lowcnt != BCW'(BRK_TICKS)) begin
                    lowcnt <= lowcnt + 1'b1;
                    if (lowcnt == BCW'(BRK_TICKS - 1)) brk_hit <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_fifo_port.sv
module uart_fifo_port
    import uart_cfg_pkg::*;
#(
    parameter int RELOAD_W   = 16,
    parameter int SEL_W      = 2,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          cfg_len,
    input  logic                cfg_par_en,
    input  logic [1:0]          cfg_par_mode,
    input  logic                cfg_flow_en,
    input  logic [SEL_W-1:0]    cfg_pre,
    input  logic [RELOAD_W-1:0] cfg_reload,
    input  logic                tx_push,
    input  logic [MAX_DATA-1:0] tx_data,
    output logic                tx_full,
    output logic                tx_empty,
    input  logic                rx_pop,
    output logic [MAX_DATA-1:0] rx_data,
    output logic                rx_empty,
    output logic                rx_full,
    input  logic                clr_err,
    output logic                err_parity,
    output logic                err_frame,
    output logic                err_overrun,
    output logic                brk_det,
    output logic                txd,
    input  logic                rxd,
    input  logic                cts_n,
    output logic                rts_n
);
    char_fmt_t           fmt;
    logic                tick;
    logic                take;
    logic [MAX_DATA-1:0] tx_head;
    logic                cts_s1, cts_s2, cts_ok;
    logic                got, frm_p, par_p, brk_p;
    logic [MAX_DATA-1:0] got_data;

    assign fmt    = '{len_code: cfg_len, par_en: cfg_par_en,
                      par_mode: par_mode_e'(cfg_par_mode)};
    assign cts_ok = !cfg_flow_en || !cts_s2;
    assign rts_n  = cfg_flow_en && rx_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            cts_s1 <= 1'b1;
            cts_s2 <= 1'b1;
        end else begin
            cts_s1 <= cts_n;
            cts_s2 <= cts_s1;
        end
    end

    uart_baud_gen #(.RELOAD_W(RELOAD_W), .SEL_W(SEL_W)) u_baud (
        .clk(clk), .rst(rst), .pre_sel(cfg_pre), .reload(cfg_reload), .tick(tick)
    );

    uart_sync_fifo #(.W(MAX_DATA), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .din(tx_data), .pop(take),
        .dout(tx_head), .empty(tx_empty), .full(tx_full)
    );

    uart_tx u_tx (
        .clk(clk), .rst(rst), .tick(tick), .fmt(fmt), .cts_ok(cts_ok),
        .have_data(!tx_empty), .din(tx_head), .take(take), .txd(txd)
    );

    uart_rx u_rx (
        .clk(clk), .rst(rst), .tick(tick), .fmt(fmt), .rxd_raw(rxd),
        .got(got), .got_data(got_data), .frm_err(frm_p), .par_err(par_p),
        .brk_hit(brk_p)
    );

    uart_sync_fifo #(.W(MAX_DATA), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(got), .din(got_data), .pop(rx_pop),
        .dout(rx_data), .empty(rx_empty), .full(rx_full)
    );

    // Sticky status: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
            brk_det     <= 1'b0;
        end else begin
            err_parity  <= (err_parity  && !clr_err) || par_p;
            err_frame   <= (err_frame   && !clr_err) || frm_p;
            err_overrun <= (err_overrun && !clr_err) || (got && rx_full);
            brk_det     <= (brk_det     && !clr_err) || brk_p;
        end
    end
endmodule

// File: rtl/uart_port_checker.sv
module uart_port_checker (
    input logic clk,
    input logic rst,
    input logic clr_err,
    input logic tx_full,
    input logic tx_empty,
    input logic rx_full,
    input logic rx_empty,
    input logic err_frame,
    input logic err_overrun,
    input logic brk_det
);
    assert_txq_flags_R8: assert property (@(posedge clk) disable iff (rst)
        tx_full |-> !tx_empty);

    assert_rxq_flags_R8: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> !rx_empty);

    assert_overrun_when_full_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overrun) |-> $past(rx_full));

    assert_frame_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (err_frame && !clr_err) |=> err_frame);

    assert_break_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (brk_det && !clr_err) |=> brk_det);
endmodule

bind uart_fifo_port uart_port_checker u_chk (
    .clk(clk), .rst(rst), .clr_err(clr_err), .tx_full(tx_full),
    .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
    .err_frame(err_frame), .err_overrun(err_overrun), .brk_det(brk_det)
);

// File: tb/sim_uart_fifo_port.sv
module sim_uart_fifo_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_len = 3'd3;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_mode = 2'd0;
    logic       cfg_flow_en = 1'b0;
    logic [1:0] cfg_pre = 2'd0;
    logic [15:0] cfg_reload = 16'd1;
    logic       tx_push = 1'b0;
    logic [8:0] tx_data = '0;
    logic       tx_full, tx_empty;
    logic       rx_pop = 1'b0;
    logic [8:0] rx_data;
    logic       rx_empty, rx_full;
    logic       clr_err = 1'b0;
    logic       err_parity, err_frame, err_overrun, brk_det;
    logic       txd;
    logic       rxd = 1'b1;
    logic       cts_n = 1'b0;
    logic       rts_n;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int BIT = 16;
    bit done = 0;
    logic [8:0] rxq[$];

    always #5 clk = ~clk;

    uart_fifo_port u0 (
        .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_mode(cfg_par_mode), .cfg_flow_en(cfg_flow_en), .cfg_pre(cfg_pre),
        .cfg_reload(cfg_reload), .tx_push(tx_push), .tx_data(tx_data),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .rx_full(rx_full), .clr_err(clr_err),
        .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
        .brk_det(brk_det), .txd(txd), .rxd(rxd), .cts_n(cts_n), .rts_n(rts_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    function automatic int nbits(input logic [2:0] code);
        return 5 + int'(code);
    endfunction

    function automatic logic [8:0] msk(input logic [8:0] d, input logic [2:0] code);
        logic [8:0] r = '0;
        for (int i = 0; i < nbits(code); i++) r[i] = d[i];
        return r;
    endfunction

    function automatic logic ref_par(input logic [8:0] d, input logic [2:0] code,
                                     input logic [1:0] mode);
        int ones = 0;
        for (int i = 0; i < nbits(code); i++) if (d[i]) ones++;
        case (mode)
            2'd0: return (ones % 2 == 0);
            2'd1: return (ones % 2 == 1);
            2'd2: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic push_tx(input logic [8:0] d);
        tx_push = 1'b1;
        tx_data = d;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
        @(negedge clk);
    endtask

    task automatic decode_tx(output logic [8:0] d, output logic par, output logic stp);
        d = '0;
        par = 1'b0;
        while (txd !== 1'b0) @(negedge clk);
        repeat (BIT / 2) @(negedge clk);
        chk("R2 start bit", txd, 1'b0);
        for (int i = 0; i < nbits(cfg_len); i++) begin
            repeat (BIT) @(negedge clk);
            d[i] = txd;
        end
        if (cfg_par_en) begin
            repeat (BIT) @(negedge clk);
            par = txd;
        end
        repeat (BIT) @(negedge clk);
        stp = txd;
    endtask

    // glitch_bit: data index whose centre gets a two-cycle inversion, -1 for none.
    task automatic send_rx(input logic [8:0] d, input logic pbit, input logic stopv,
                           input int glitch_bit);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < nbits(cfg_len); i++) begin
            rxd = d[i];
            if (i == glitch_bit) begin
                repeat (BIT / 2 - 1) @(negedge clk);
                rxd = ~d[i];
                repeat (2) @(negedge clk);
                rxd = d[i];
                repeat (BIT / 2 - 1) @(negedge clk);
            end else begin
                repeat (BIT) @(negedge clk);
            end
        end
        if (cfg_par_en) begin
            rxd = pbit;
            repeat (BIT) @(negedge clk);
        end
        rxd = stopv;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [8:0] d;
        logic p, s;
        int w;
        logic [2:0] lens [4]  = '{3'd0, 3'd2, 3'd4, 3'd1};
        logic [1:0] modes [4] = '{2'd1, 2'd0, 2'd2, 2'd3};
        logic [8:0] vals [4]  = '{9'h013, 9'h055, 9'h1A3, 9'h02A};

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state (R8)
        chk("R8 reset txd", txd, 1'b1);
        chk("R8 reset tx_empty", tx_empty, 1'b1);
        chk("R8 reset rx_empty", rx_empty, 1'b1);
        chk("R8 reset flags", {err_parity, err_frame, err_overrun, brk_det}, 4'b0);
        chk("R11 reset rts_n", rts_n, 1'b0);

        // R2: 8 data bits, no parity
        push_tx(9'h0A5);
        decode_tx(d, p, s);
        chk("R2 tx data 8N", d, 9'h0A5);
        chk("R2 stop bit", s, 1'b1);
        repeat (BIT) @(negedge clk);

        // R3 / R4: each length with a different parity rule
        for (int k = 0; k < 4; k++) begin
            cfg_len = lens[k];
            cfg_par_en = 1'b1;
            cfg_par_mode = modes[k];
            push_tx(vals[k]);
            decode_tx(d, p, s);
            chk("R3 tx length data", d, msk(vals[k], lens[k]));
            chk("R4 tx parity bit", p, ref_par(vals[k], lens[k], modes[k]));
            chk("R2 stop after parity", s, 1'b1);
            repeat (BIT) @(negedge clk);
        end
        cfg_len = 3'd3;
        cfg_par_en = 1'b0;

        // R1: bit time with prescaler 2 and reload 2 -> 48 cycles
        cfg_pre = 2'd1;
        cfg_reload = 16'd2;
        push_tx(9'h001);
        while (txd !== 1'b0) @(negedge clk);
        w = 0;
        while (txd === 1'b0) begin
            w++;
            @(negedge clk);
        end
        chk("R1 start bit width", w, 48);
        repeat (12 * 48) @(negedge clk);
        cfg_pre = 2'd0;
        cfg_reload = 16'd1;
        BIT = 16;
        repeat (BIT) @(negedge clk);

        // R10 / R8: held-off transmit queue, fifth push ignored
        cfg_flow_en = 1'b1;
        cts_n = 1'b1;
        repeat (4) @(negedge clk);
        for (int k = 1; k <= 5; k++) push_tx(9'(k * 9'h011));
        chk("R8 tx_full after 5 pushes", tx_full, 1'b1);
        chk("R11 rts_n with empty rx", rts_n, 1'b0);
        w = 0;
        repeat (300) begin
            @(negedge clk);
            if (txd !== 1'b1) w++;
        end
        chk("R10 txd held high while cts_n high", w, 0);
        cts_n = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            decode_tx(d, p, s);
            chk("R10 released frame order", d, 9'(k * 9'h011));
        end
        w = 0;
        repeat (12 * BIT) begin
            @(negedge clk);
            if (txd !== 1'b1) w++;
        end
        chk("R8 ignored fifth push not sent", w, 0);
        chk("R8 tx_empty after drain", tx_empty, 1'b1);
        cfg_flow_en = 1'b0;

        // R2 receive path, 8N
        send_rx(9'h03C, 1'b0, 1'b1, -1);
        rxq.push_back(9'h03C);
        chk("R2 rx not empty", rx_empty, 1'b0);
        chk("R2 rx data 8N", rx_data, rxq.pop_front());
        pop_rx();
        chk("R8 rx empty after pop", rx_empty, 1'b1);

        // R3 / R5: 9 bits even parity and 5 bits odd parity, correct parity
        cfg_par_en = 1'b1;
        cfg_len = 3'd4;
        cfg_par_mode = 2'd1;
        send_rx(9'h155, ref_par(9'h155, 3'd4, 2'd1), 1'b1, -1);
        chk("R3 rx 9-bit data", rx_data, 9'h155);
        pop_rx();
        cfg_len = 3'd0;
        cfg_par_mode = 2'd0;
        send_rx(9'h1FF, ref_par(9'h1FF, 3'd0, 2'd0), 1'b1, -1);
        chk("R3 rx 5-bit zero-extended", rx_data, 9'h01F);
        chk("R5 no parity error on good parity", err_parity, 1'b0);
        pop_rx();

        // R5: wrong parity, character kept
        cfg_len = 3'd2;
        cfg_par_mode = 2'd1;
        send_rx(9'h041, ~ref_par(9'h041, 3'd2, 2'd1), 1'b1, -1);
        chk("R5 parity error flag", err_parity, 1'b1);
        chk("R5 character still stored", rx_data, 9'h041);
        pop_rx();
        pulse_clr();
        cfg_len = 3'd3;
        cfg_par_en = 1'b0;

        // R7: low stop bit
        send_rx(9'h0F0, 1'b0, 1'b0, -1);
        chk("R7 framing error flag", err_frame, 1'b1);
        chk("R7 character discarded", rx_empty, 1'b1);
        pulse_clr();
        send_rx(9'h05A, 1'b0, 1'b1, -1);
        chk("R7 receiver recovers", rx_data, 9'h05A);
        pop_rx();

        // R6: glitch at a bit centre, and a short false start
        send_rx(9'h000, 1'b0, 1'b1, 3);
        chk("R6 centre glitch rejected", rx_data, 9'h000);
        pop_rx();
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT) @(negedge clk);
        chk("R6 false start stores nothing", rx_empty, 1'b1);
        chk("R6 false start no framing error", err_frame, 1'b0);

        // R9 / R11: overflow the receive queue
        cfg_flow_en = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            send_rx(9'(k), 1'b0, 1'b1, -1);
            if (k <= 4) rxq.push_back(9'(k));
            if (k == 4) begin
                chk("R11 rts_n high when rx full", rts_n, 1'b1);
                chk("R9 no overrun at exactly full", err_overrun, 1'b0);
            end
        end
        chk("R9 overrun flag", err_overrun, 1'b1);
        for (int k = 1; k <= 4; k++) begin
            chk("R9 kept order", rx_data, rxq.pop_front());
            pop_rx();
        end
        chk("R9 fifth character dropped", rx_empty, 1'b1);
        chk("R11 rts_n low after drain", rts_n, 1'b0);
        cfg_flow_en = 1'b0;
        chk("R11 rts_n low with flow off", rts_n, 1'b0);

        // R12 / R13: break, then clear, then an all-zero character
        rxd = 1'b0;
        repeat (13 * BIT) @(negedge clk);
        chk("R12 break detected", brk_det, 1'b1);
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        pulse_clr();
        chk("R13 flags cleared", {err_parity, err_frame, err_overrun, brk_det}, 4'b0);
        send_rx(9'h000, 1'b0, 1'b1, -1);
        chk("R12 zero character is not a break", brk_det, 1'b0);
        chk("R12 zero character received", rx_data, 9'h000);
        pop_rx();

        summary();
    end
endmodule